// File: doc/BRIEF.md
# Typed Local Port Demultiplexer

A time-multiplexed network model walks its nodes one instance at a time. Every node has a local port, and what sits behind that port differs from node to node: a processor core, a memory controller, or nothing at all. This block sits between the shared local-port output of the node model and the two real consumers. It keeps a small table with a 2-bit attachment code for each node. It then steers each outgoing local message to the core send port, to the memory-controller send port, or to a null sink that discards it. The router logic never learns what a node is attached to.

The table is filled at start-up from a stream of parameter beats, one beat per node in ascending node order. Cores are numbered in node order, so the core port index is the node ID itself. Memory controllers are numbered densely in the order the memory-typed nodes appear in the stream. That rank is worked out while the table loads, so no counting happens on the message path. Outputs are registered, which gives one cycle of latency from an accepted message to its send port.

Top module: `lp_local_demux`

## Requirements
- R1: Out of reset both send ports are idle and every table entry holds the null code, so any message sent before loading produces no output.
- R2: Each beat with `cfg_valid` high writes `cfg_code` into the next table entry, starting at node 0. A beat with `cfg_last` high ends the load, and the following beat goes to node 0. After a beat for node N_NODES-1 the next beat also goes to node 0.
- R3: For a node whose code is 0 (core) and whose ID is below N_CPUS, a message accepted in cycle t is presented on the core port in cycle t+1, and `cpu_idx` equals the node ID.
- R4: For a node whose code is 1 (memory controller), the message appears on the memory port in cycle t+1. `mem_idx` equals the number of code-1 beats that came before it in the same load sequence.
- R5: A message for a node with code 2 (null) or code 3 (reserved) is dropped, and neither port becomes valid.
- R6: At most one of `cpu_valid` and `mem_valid` is high in any cycle. Neither is high unless `in_valid` was high in the cycle before.
- R7: A message for a core-typed node whose ID is N_CPUS or larger is dropped.
- R8: A message for a memory-typed node whose rank is N_MEMS or larger is dropped.
- R9: A new load sequence overwrites entries from node 0 upward and restarts memory ranking at 0. Entries beyond the last beat keep their previous code and rank.
- R10: The message word reaches the selected port unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_valid | input | 1 | Table load beat present |
| cfg_code | input | 2 | Attachment code for the next node (0 core, 1 memory, 2 null, 3 reserved) |
| cfg_last | input | 1 | Final beat of a load sequence |
| in_valid | input | 1 | Local-port message present |
| in_node | input | $clog2(N_NODES) | Node instance sending the message |
| in_msg | input | MSG_W | Message word |
| cpu_valid | output | 1 | Core send port valid |
| cpu_idx | output | $clog2(N_CPUS) | Core instance index |
| cpu_msg | output | MSG_W | Core message word |
| mem_valid | output | 1 | Memory-controller send port valid |
| mem_idx | output | $clog2(N_MEMS) | Memory-controller instance index |
| mem_msg | output | MSG_W | Memory-controller message word |

## Verification
A wrong table entry or a wrong stored rank shows up one cycle after the first message for that node. It appears as a message on the wrong port, a wrong `mem_idx`, or a message that vanishes. A load pointer that drifts shifts every later node's type, so sweeping all nodes back to back after each load exposes it at once. A rank counter that is not cleared shows up as wrong memory indices only after a reload, so the bench reloads the table and checks the ranks again.

// File: rtl/lp_demux_pkg.sv
// Package: shared attachment codes for the local port demultiplexer.
// Assumes a 2-bit code per node; the reserved value behaves as null.
package lp_demux_pkg;
    typedef enum logic [1:0] {
        LP_CORE = 2'd0,
        LP_MEMC = 2'd1,
        LP_NONE = 2'd2,
        LP_RSVD = 2'd3
    } lp_kind_e;
endpackage

// File: rtl/lp_cfg_loader.sv
// Module: lp_cfg_loader
// Turns the parameter stream into table writes. It tracks the next node
// slot and the running count of memory-typed beats in the current load
// sequence. Assumes one beat per node, in ascending node order.
module lp_cfg_loader #(
    parameter int N_NODES = 16,
    parameter int N_MEMS  = 3,
    localparam int NIW = (N_NODES > 1) ? $clog2(N_NODES) : 1,
    localparam int CW  = $clog2(N_NODES + 1),
    localparam int MIW = (N_MEMS > 1) ? $clog2(N_MEMS) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_valid,
    input  logic [1:0]     cfg_code,
    input  logic           cfg_last,
    output logic           wr_en,
    output logic [NIW-1:0] wr_node,
    output logic [1:0]     wr_code,
    output logic [MIW-1:0] wr_rank,
    output logic           wr_rank_ok
);
    import lp_demux_pkg::*;

    logic [NIW-1:0] ptr_q;
    logic [CW-1:0]  mcnt_q;
    logic           is_mem;
    logic           wrap;

    // Purpose: classify the beat and detect the end of a sequence.
    always_comb begin
        is_mem = (cfg_code == LP_MEMC);
        wrap   = cfg_last || (ptr_q == NIW'(N_NODES - 1));
    end

    // Purpose: present the write for the current beat.
    always_comb begin
        wr_en      = cfg_valid;
        wr_node    = ptr_q;
        wr_code    = cfg_code;
        wr_rank    = MIW'(mcnt_q);
        wr_rank_ok = (mcnt_q < CW'(N_MEMS));
    end

    // Purpose: advance the node pointer and the memory rank counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            mcnt_q <= '0;
        end else if (cfg_valid) begin
            if (wrap) begin
                ptr_q  <= '0;
                mcnt_q <= '0;
            end else begin
                ptr_q <= ptr_q + 1'b1;
                if (is_mem) begin
                    mcnt_q <= mcnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lp_type_table.sv
// Module: lp_type_table
// Per-node storage of attachment code, memory rank and rank validity.
// One write port, one combinational read port. Assumes the read index
// is already range-limited by the caller.
module lp_type_table #(
    parameter int N_NODES = 16,
    parameter int N_MEMS  = 3,
    localparam int NIW = (N_NODES > 1) ? $clog2(N_NODES) : 1,
    localparam int MIW = (N_MEMS > 1) ? $clog2(N_MEMS) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [NIW-1:0] wr_node,
    input  logic [1:0]     wr_code,
    input  logic [MIW-1:0] wr_rank,
    input  logic           wr_rank_ok,
    input  logic [NIW-1:0] rd_node,
    output logic [1:0]     rd_code,
    output logic [MIW-1:0] rd_rank,
    output logic           rd_rank_ok
);
    import lp_demux_pkg::*;

    logic [1:0]     code_q [N_NODES];
    logic [MIW-1:0] rank_q [N_NODES];
    logic           rok_q  [N_NODES];

    // One storage slot per node, each with its own write decode.
    for (genvar g = 0; g < N_NODES; g++) begin : g_slot
        // Purpose: reset the slot to null or capture a load beat.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                code_q[g] <= LP_NONE;
                rank_q[g] <= '0;
                rok_q[g]  <= 1'b0;
            end else if (wr_en && (wr_node == NIW'(g))) begin
                code_q[g] <= wr_code;
                rank_q[g] <= wr_rank;
                rok_q[g]  <= wr_rank_ok;
            end
        end
    end

    // Purpose: read the slot named by the incoming message.
    always_comb begin
        rd_code    = code_q[rd_node];
        rd_rank    = rank_q[rd_node];
        rd_rank_ok = rok_q[rd_node];
    end
endmodule

// File: rtl/lp_route_decode.sv
// Module: lp_route_decode
// Chooses the destination of one message from its node's table entry.
// Drops null, reserved, out-of-range core and out-of-range memory cases.
// Assumes N_CPUS does not exceed N_NODES.
module lp_route_decode #(
    parameter int N_NODES = 16,
    parameter int N_CPUS  = 12,
    parameter int N_MEMS  = 3,
    localparam int NIW = (N_NODES > 1) ? $clog2(N_NODES) : 1,
    localparam int CIW = (N_CPUS > 1) ? $clog2(N_CPUS) : 1,
    localparam int MIW = (N_MEMS > 1) ? $clog2(N_MEMS) : 1
) (
    input  logic           in_valid,
    input  logic [NIW-1:0] in_node,
    input  logic [1:0]     code,
    input  logic [MIW-1:0] rank,
    input  logic           rank_ok,
    output logic           to_cpu,
    output logic [CIW-1:0] cpu_sel_idx,
    output logic           to_mem,
    output logic [MIW-1:0] mem_sel_idx
);
    import lp_demux_pkg::*;

    logic node_ok;
    logic core_ok;

    // The range checks only exist when the parameters leave room for them.
    if (N_NODES == (1 << NIW)) begin : g_node_full
        assign node_ok = 1'b1;
    end else begin : g_node_part
        assign node_ok = (int'(in_node) < N_NODES);
    end

    if (N_CPUS >= (1 << NIW)) begin : g_core_full
        assign core_ok = 1'b1;
    end else begin : g_core_part
        assign core_ok = (int'(in_node) < N_CPUS);
    end

    // Purpose: at most one destination, only for a valid message.
    always_comb begin
        to_cpu      = in_valid && node_ok && core_ok && (code == LP_CORE);
        to_mem      = in_valid && node_ok && rank_ok && (code == LP_MEMC);
        cpu_sel_idx = CIW'(in_node);
        mem_sel_idx = rank;
    end
endmodule

// File: rtl/lp_out_stage.sv
// Module: lp_out_stage
// Registers both send ports. Data fields load only when their port is
// selected; valid flags clear when nothing is sent.
module lp_out_stage #(
    parameter int MSG_W = 32,
    parameter int CIW   = 4,
    parameter int MIW   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             to_cpu,
    input  logic [CIW-1:0]   cpu_sel_idx,
    input  logic             to_mem,
    input  logic [MIW-1:0]   mem_sel_idx,
    input  logic [MSG_W-1:0] msg,
    output logic             cpu_valid,
    output logic [CIW-1:0]   cpu_idx,
    output logic [MSG_W-1:0] cpu_msg,
    output logic             mem_valid,
    output logic [MIW-1:0]   mem_idx,
    output logic [MSG_W-1:0] mem_msg
);
    // Purpose: valid flags, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_valid <= 1'b0;
            mem_valid <= 1'b0;
        end else begin
            cpu_valid <= to_cpu;
            mem_valid <= to_mem;
        end
    end

    // Purpose: core port payload, loaded only when the core is chosen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_idx <= '0;
            cpu_msg <= '0;
        end else if (to_cpu) begin
            cpu_idx <= cpu_sel_idx;
            cpu_msg <= msg;
        end
    end

    // Purpose: memory port payload, loaded only when memory is chosen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_idx <= '0;
            mem_msg <= '0;
        end else if (to_mem) begin
            mem_idx <= mem_sel_idx;
            mem_msg <= msg;
        end
    end
endmodule

// File: rtl/lp_local_demux.sv
// Module: lp_local_demux (top)
// Steers local-port messages of a multiplexed node model to the core
// port, the memory-controller port or a null sink, by a per-node code
// table streamed in at start-up. One cycle from input to output.
// Assumes N_CPUS <= N_NODES and N_MEMS <= N_NODES.
module lp_local_demux #(
    parameter int N_NODES = 16,
    parameter int N_CPUS  = 12,
    parameter int N_MEMS  = 3,
    parameter int MSG_W   = 32,
    localparam int NIW = (N_NODES > 1) ? $clog2(N_NODES) : 1,
    localparam int CIW = (N_CPUS > 1) ? $clog2(N_CPUS) : 1,
    localparam int MIW = (N_MEMS > 1) ? $clog2(N_MEMS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_valid,
    input  logic [1:0]       cfg_code,
    input  logic             cfg_last,
    input  logic             in_valid,
    input  logic [NIW-1:0]   in_node,
    input  logic [MSG_W-1:0] in_msg,
    output logic             cpu_valid,
    output logic [CIW-1:0]   cpu_idx,
    output logic [MSG_W-1:0] cpu_msg,
    output logic             mem_valid,
    output logic [MIW-1:0]   mem_idx,
    output logic [MSG_W-1:0] mem_msg
);
    logic           wr_en;
    logic [NIW-1:0] wr_node;
    logic [1:0]     wr_code;
    logic [MIW-1:0] wr_rank;
    logic           wr_rank_ok;
    logic [1:0]     rd_code;
    logic [MIW-1:0] rd_rank;
    logic           rd_rank_ok;
    logic           to_cpu;
    logic           to_mem;
    logic [CIW-1:0] cpu_sel_idx;
    logic [MIW-1:0] mem_sel_idx;

    lp_cfg_loader #(.N_NODES(N_NODES), .N_MEMS(N_MEMS)) u_loader (
        .clk(clk), .rst_n(rst_n),
        .cfg_valid(cfg_valid), .cfg_code(cfg_code), .cfg_last(cfg_last),
        .wr_en(wr_en), .wr_node(wr_node), .wr_code(wr_code),
        .wr_rank(wr_rank), .wr_rank_ok(wr_rank_ok)
    );

    lp_type_table #(.N_NODES(N_NODES), .N_MEMS(N_MEMS)) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_node(wr_node), .wr_code(wr_code),
        .wr_rank(wr_rank), .wr_rank_ok(wr_rank_ok),
        .rd_node(in_node), .rd_code(rd_code), .rd_rank(rd_rank),
        .rd_rank_ok(rd_rank_ok)
    );

    lp_route_decode #(.N_NODES(N_NODES), .N_CPUS(N_CPUS), .N_MEMS(N_MEMS)) u_decode (
        .in_valid(in_valid), .in_node(in_node),
        .code(rd_code), .rank(rd_rank), .rank_ok(rd_rank_ok),
        .to_cpu(to_cpu), .cpu_sel_idx(cpu_sel_idx),
        .to_mem(to_mem), .mem_sel_idx(mem_sel_idx)
    );

    lp_out_stage #(.MSG_W(MSG_W), .CIW(CIW), .MIW(MIW)) u_out (
        .clk(clk), .rst_n(rst_n),
        .to_cpu(to_cpu), .cpu_sel_idx(cpu_sel_idx),
        .to_mem(to_mem), .mem_sel_idx(mem_sel_idx), .msg(in_msg),
        .cpu_valid(cpu_valid), .cpu_idx(cpu_idx), .cpu_msg(cpu_msg),
        .mem_valid(mem_valid), .mem_idx(mem_idx), .mem_msg(mem_msg)
    );
endmodule

// File: rtl/lp_local_demux_chk.sv
// Module: lp_local_demux_chk
// Port-level properties of the demultiplexer, bound to every instance.
module lp_local_demux_chk #(
    parameter int N_NODES = 16,
    parameter int N_CPUS  = 12,
    parameter int N_MEMS  = 3,
    parameter int MSG_W   = 32,
    localparam int NIW = (N_NODES > 1) ? $clog2(N_NODES) : 1,
    localparam int CIW = (N_CPUS > 1) ? $clog2(N_CPUS) : 1,
    localparam int MIW = (N_MEMS > 1) ? $clog2(N_MEMS) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [NIW-1:0]   in_node,
    input logic [MSG_W-1:0] in_msg,
    input logic             cpu_valid,
    input logic [CIW-1:0]   cpu_idx,
    input logic [MSG_W-1:0] cpu_msg,
    input logic             mem_valid,
    input logic [MIW-1:0]   mem_idx,
    input logic [MSG_W-1:0] mem_msg
);
    AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_valid && mem_valid)); // R6
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid || mem_valid) |-> $past(in_valid)); // R6
    AST_CORE_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_valid |-> (cpu_idx == CIW'($past(in_node)))); // R3
    AST_CORE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_valid |-> (int'($past(in_node)) < N_CPUS)); // R7
    AST_MEM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (int'(mem_idx) < N_MEMS)); // R8
    AST_CORE_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_valid |-> (cpu_msg == $past(in_msg))); // R10
    AST_MEM_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_msg == $past(in_msg))); // R10
endmodule

bind lp_local_demux lp_local_demux_chk #(
    .N_NODES(N_NODES), .N_CPUS(N_CPUS), .N_MEMS(N_MEMS), .MSG_W(MSG_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_node(in_node),
    .in_msg(in_msg), .cpu_valid(cpu_valid), .cpu_idx(cpu_idx),
    .cpu_msg(cpu_msg), .mem_valid(mem_valid), .mem_idx(mem_idx),
    .mem_msg(mem_msg)
);

// File: tb/lp_local_demux_test.sv
// Directed bench for lp_local_demux. It keeps its own model of the table:
// the code per node and the memory rank taken from the load order.
module lp_local_demux_test;
    localparam int N_NODES = 16;
    localparam int N_CPUS  = 12;
    localparam int N_MEMS  = 3;
    localparam int MSG_W   = 32;
    localparam int NIW = $clog2(N_NODES);
    localparam int CIW = $clog2(N_CPUS);
    localparam int MIW = $clog2(N_MEMS);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_valid = 1'b0;
    logic [1:0]       cfg_code = '0;
    logic             cfg_last = 1'b0;
    logic             in_valid = 1'b0;
    logic [NIW-1:0]   in_node = '0;
    logic [MSG_W-1:0] in_msg = '0;
    logic             cpu_valid;
    logic [CIW-1:0]   cpu_idx;
    logic [MSG_W-1:0] cpu_msg;
    logic             mem_valid;
    logic [MIW-1:0]   mem_idx;
    logic [MSG_W-1:0] mem_msg;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int m_code [N_NODES];
    int m_rank [N_NODES];
    int m_ptr = 0;
    int m_cnt = 0;

    always #10 clk = ~clk;

    lp_local_demux #(.N_NODES(N_NODES), .N_CPUS(N_CPUS), .N_MEMS(N_MEMS),
                     .MSG_W(MSG_W)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_code(cfg_code),
        .cfg_last(cfg_last), .in_valid(in_valid), .in_node(in_node),
        .in_msg(in_msg), .cpu_valid(cpu_valid), .cpu_idx(cpu_idx),
        .cpu_msg(cpu_msg), .mem_valid(mem_valid), .mem_idx(mem_idx),
        .mem_msg(mem_msg)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Send one load beat and update the model: code goes to the next slot,
    // memory rank counts memory beats earlier in the same sequence.
    task automatic load_beat(input int code, input bit last);
        @(negedge clk);
        cfg_valid = 1'b1;
        cfg_code  = 2'(code);
        cfg_last  = last;
        m_code[m_ptr] = code;
        m_rank[m_ptr] = m_cnt;
        if (last || m_ptr == N_NODES - 1) begin
            m_ptr = 0;
            m_cnt = 0;
        end else begin
            m_ptr++;
            if (code == 1) m_cnt++;
        end
        @(negedge clk);
        cfg_valid = 1'b0;
        cfg_last  = 1'b0;
    endtask

    // Check the outputs for a message of node n with word w sent one edge ago.
    task automatic expect_route(input int n, input logic [MSG_W-1:0] w, input string tag);
        bit want_cpu;
        bit want_mem;
        want_cpu = (m_code[n] == 0) && (n < N_CPUS);
        want_mem = (m_code[n] == 1) && (m_rank[n] < N_MEMS);
        chk(cpu_valid == want_cpu, {tag, " cpu_valid"}, cpu_valid, want_cpu);
        chk(mem_valid == want_mem, {tag, " mem_valid"}, mem_valid, want_mem);
        if (want_cpu) begin
            chk(cpu_idx == CIW'(n), {tag, " R3 cpu_idx"}, cpu_idx, n);
            chk(cpu_msg == w, {tag, " R10 cpu_msg"}, cpu_msg, w);
        end
        if (want_mem) begin
            chk(mem_idx == MIW'(m_rank[n]), {tag, " R4 mem_idx"}, mem_idx, m_rank[n]);
            chk(mem_msg == w, {tag, " R10 mem_msg"}, mem_msg, w);
        end
    endtask

    // Send every node back to back, checking each result one cycle later.
    task automatic sweep(input logic [MSG_W-1:0] base, input string tag);
        for (int k = 0; k <= N_NODES; k++) begin
            @(negedge clk);
            if (k > 0) expect_route(k - 1, base ^ MSG_W'(k - 1), tag);
            if (k < N_NODES) begin
                in_valid = 1'b1;
                in_node  = NIW'(k);
                in_msg   = base ^ MSG_W'(k);
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    // R1: idle after reset, and an unloaded table drops everything.
    task automatic t_reset();
        for (int i = 0; i < N_NODES; i++) begin
            m_code[i] = 2;
            m_rank[i] = 0;
        end
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(cpu_valid == 1'b0, "R1 cpu_valid after reset", cpu_valid, 0);
        chk(mem_valid == 1'b0, "R1 mem_valid after reset", mem_valid, 0);
        sweep(32'h1111_0000, "R1 unloaded");
    endtask

    // R2 R3 R4 R5 R7 R8: full table with every code and the range cases.
    task automatic t_full_load();
        int codes [N_NODES] = '{0,1,0,2,3,1,0,0,1,0,0,1,0,0,2,0};
        for (int i = 0; i < N_NODES; i++) load_beat(codes[i], i == N_NODES - 1);
        sweep(32'hA5A5_0000, "R2 R5 R7 R8 full");
        sweep(32'h0F0F_FFF0, "R10 second pattern");
    endtask

    // R6: no output for a cycle without in_valid, even on a core node.
    task automatic t_idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_node  = '0;
        in_msg   = 32'hDEAD_BEEF;
        @(negedge clk);
        chk(!cpu_valid && !mem_valid, "R6 idle no output", {cpu_valid, mem_valid}, 0);
    endtask

    // R9: short reload ending with cfg_last; later entries keep old values.
    task automatic t_reload();
        load_beat(1, 1'b0);
        load_beat(1, 1'b0);
        load_beat(0, 1'b0);
        load_beat(2, 1'b1);
        sweep(32'h5555_0000, "R9 reload");
    endtask

    // R2: a sequence of N_NODES beats without cfg_last wraps to node 0.
    task automatic t_wrap();
        for (int i = 0; i < N_NODES; i++) load_beat((i % 3 == 0) ? 1 : 0, 1'b0);
        load_beat(2, 1'b0);
        load_beat(1, 1'b1);
        sweep(32'h3C3C_0000, "R2 wrap");
    endtask

    initial begin
        t_reset();
        t_full_load();
        t_idle();
        t_reload();
        t_wrap();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule